// File: doc/BRIEF.md
# USB device control and status word

This block is the top-level control register of a USB device controller. Software reaches it through a simple single-cycle register bus. One 8-bit field, zero-extended to the bus width, mixes four kinds of access:
- plain read/write bits: the global enable and two interrupt masks;
- sticky event flags that are cleared by writing 1;
- a write-1-to-set wake-up request;
- a live, read-only view of whether the line is carrying a bus reset.

The line-state logic reports three kinds of event as single-cycle pulses: host reset, suspend and resume. Each pulse sets a sticky flag. The flags and their masks form one level-sensitive interrupt.

The enable bit also drives the rest of the controller. While it is clear, a soft-reset output holds the shifters and FIFOs in reset, and the pad drivers are released to high impedance. While it is clear, the block also ignores incoming events.

Top module: `usbd_ctl_reg`

## Requirements
- R1: After `rst_n` is released, the word at the register address reads 0xA2 when `line_rst_active` is 0. Both masks (bit 7 and bit 5) are 1. The flags, the wake bit and the enable are 0. `ctrl_soft_rst` and `pad_hiz` are 1, and `irq` is 0.
- R2: Bit 0 (enable) is read/write. `ctrl_soft_rst` and `pad_hiz` equal the inverse of the stored enable, from the cycle after the write.
- R3: Bit 1 is read-only and reads the inverse of `line_rst_active` in the same cycle. Writes to it have no effect.
- R4: Writing 1 to bit 2 while the enable is already 1 produces `resume_pulse` high for exactly the one cycle after the write. Writing 0, or writing 1 while disabled, produces no pulse. Bit 2 always reads 0.
- R5: The flags are: bit 6 for host reset, set by `ev_host_reset`; bit 4 for suspend, set by `ev_suspend`; and bit 3 for resume, set by `ev_resume`. An event pulse while enabled sets its flag at the next clock edge. A flag stays set until a write with a 1 in its bit position. Writing 0 leaves it unchanged.
- R6: Bit 7 masks the host-reset interrupt. Bit 5 masks both the suspend and resume interrupts. A mask value of 1 blocks the interrupt, and both masks are read/write.
- R7: `irq` = (bit6 & ~bit7) | ((bit4 | bit3) & ~bit5). It follows the stored bits in the same cycle they are visible on a read.
- R8: When an event and a write-1-to-clear hit the same flag in the same cycle, the flag ends up set.
- R9: While the enable is 0, event pulses leave every flag unchanged.
- R10: Bits above 7 read 0. When `bus_sel` is low or `bus_addr` differs from the register address, `bus_rdata` is 0 and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| line_rst_active | input | 1 | Level: a bus reset is present on the line |
| ev_host_reset | input | 1 | Pulse: host reset detected |
| ev_suspend | input | 1 | Pulse: suspend detected |
| ev_resume | input | 1 | Pulse: resume detected |
| irq | output | 1 | Combined masked interrupt |
| ctrl_soft_rst | output | 1 | Reset to the rest of the controller |
| pad_hiz | output | 1 | Release D+/D- drivers to high impedance |
| resume_pulse | output | 1 | One-cycle wake request to the suspend logic |

## Verification
Reads are combinational, so `bus_rdata` and the live line bit are sampled a settling delay after the address is driven, with no clock edge needed. A write or an event pulse lands on the next rising edge. The stored bits, `irq`, `ctrl_soft_rst` and `pad_hiz` are therefore checked at the falling edge that follows it. `resume_pulse` is registered, so it is checked high at that same falling edge and low one cycle later. The bench drives every input at a falling edge and samples only at falling edges. It sweeps all four mask settings against all eight flag patterns.

// File: rtl/usbd_ctl_pkg.sv
package usbd_ctl_pkg;
   localparam int CTL_W = 8;
   localparam int B_EN    = 0;
   localparam int B_LINE  = 1;
   localparam int B_WAKE  = 2;
   localparam int B_RESF  = 3;
   localparam int B_SUSF  = 4;
   localparam int B_SRMSK = 5;
   localparam int B_RSTF  = 6;
   localparam int B_RSMSK = 7;
   localparam int N_FLAG  = 3;
   // flag index 0 = resume, 1 = suspend, 2 = host reset
   localparam int FLAG_POS [N_FLAG] = '{B_RESF, B_SUSF, B_RSTF};
endpackage

// File: rtl/usbd_w1c_flag.sv
module usbd_w1c_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_r;

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_r <= 1'b0;
            else if (set_i) q_r <= 1'b1;
            else if (clr_i) q_r <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_r <= 1'b0;
            else if (clr_i) q_r <= 1'b0;
            else if (set_i) q_r <= 1'b1;
         end
      end
   endgenerate

   assign q_o = q_r;
endmodule

// File: rtl/usbd_irq_comb.sv
module usbd_irq_comb import usbd_ctl_pkg::*; (
   input  logic [N_FLAG-1:0] flag_i,
   input  logic              rst_mask_i,
   input  logic              sr_mask_i,
   output logic              req_o
);
   logic rst_req, sr_req;

   always_comb begin
      rst_req = flag_i[2] & ~rst_mask_i;
      sr_req  = (flag_i[1] | flag_i[0]) & ~sr_mask_i;
      req_o   = rst_req | sr_req;
   end
endmodule

// File: rtl/usbd_ctl_reg.sv
module usbd_ctl_reg import usbd_ctl_pkg::*; #(
   parameter int              DATA_W   = 32,
   parameter int              ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0,
   parameter bit              SET_WINS = 1'b1,
   parameter bit              IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              line_rst_active,
   input  logic              ev_host_reset,
   input  logic              ev_suspend,
   input  logic              ev_resume,
   output logic              irq,
   output logic              ctrl_soft_rst,
   output logic              pad_hiz,
   output logic              resume_pulse
);
   localparam int PAD_W = DATA_W - CTL_W;

   generate
      if (DATA_W < CTL_W) begin : g_bad_width
         $error("usbd_ctl_reg: DATA_W must be at least 8");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("usbd_ctl_reg: ADDR_W must be at least 1");
      end
   endgenerate

   logic              hit, wr_hit;
   logic              en_q, rst_mask_q, sr_mask_q, wake_q;
   logic [N_FLAG-1:0] ev_v, flag_q;
   logic [CTL_W-1:0]  word8;
   logic              irq_c;

   assign hit    = bus_sel && (bus_addr == REG_ADDR);
   assign wr_hit = hit && bus_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         rst_mask_q <= 1'b1;
         sr_mask_q  <= 1'b1;
         wake_q     <= 1'b0;
      end else begin
         wake_q <= wr_hit && bus_wdata[B_WAKE] && en_q;
         if (wr_hit) begin
            en_q       <= bus_wdata[B_EN];
            rst_mask_q <= bus_wdata[B_RSMSK];
            sr_mask_q  <= bus_wdata[B_SRMSK];
         end
      end
   end

   assign ev_v = {ev_host_reset, ev_suspend, ev_resume};

   generate
      for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
         logic set_c, clr_c;
         assign set_c = en_q && ev_v[i];
         assign clr_c = wr_hit && bus_wdata[FLAG_POS[i]];
         usbd_w1c_flag #(.SET_WINS(SET_WINS)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_c),
            .clr_i (clr_c),
            .q_o   (flag_q[i])
         );
      end
   endgenerate

   always_comb begin
      word8          = '0;
      word8[B_EN]    = en_q;
      word8[B_LINE]  = ~line_rst_active;
      word8[B_WAKE]  = 1'b0;
      word8[B_RESF]  = flag_q[0];
      word8[B_SUSF]  = flag_q[1];
      word8[B_SRMSK] = sr_mask_q;
      word8[B_RSTF]  = flag_q[2];
      word8[B_RSMSK] = rst_mask_q;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign bus_rdata = hit ? {{PAD_W{1'b0}}, word8} : '0;
      end else begin : g_nopad
         assign bus_rdata = hit ? word8 : '0;
      end
   endgenerate

   usbd_irq_comb u_irq (
      .flag_i     (flag_q),
      .rst_mask_i (rst_mask_q),
      .sr_mask_i  (sr_mask_q),
      .req_o      (irq_c)
   );

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_c;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_c;
      end
   endgenerate

   assign ctrl_soft_rst = ~en_q;
   assign pad_hiz       = ~en_q;
   assign resume_pulse  = wake_q;
endmodule

// File: rtl/usbd_ctl_reg_chk.sv
module usbd_ctl_reg_chk import usbd_ctl_pkg::*; #(
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0,
   parameter bit                SET_WINS = 1'b1,
   parameter bit                IRQ_REG  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              ev_suspend,
   input logic              irq,
   input logic              ctrl_soft_rst,
   input logic              pad_hiz,
   input logic              resume_pulse,
   input logic [N_FLAG-1:0] flag_q
);
   logic wr_hit;
   assign wr_hit = bus_sel && bus_wr && (bus_addr == REG_ADDR);

   a_r2_disable_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !bus_wdata[B_EN]) |=> (ctrl_soft_rst && pad_hiz));

   a_r2_enable_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && bus_wdata[B_EN]) |=> (!ctrl_soft_rst && !pad_hiz));

   a_r4_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      resume_pulse |-> $past(wr_hit && bus_wdata[B_WAKE] && !ctrl_soft_rst));

   a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_suspend && !(wr_hit && bus_wdata[B_SUSF])) |=> $stable(flag_q[1]));

   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (SET_WINS && !ctrl_soft_rst && ev_suspend) |=> flag_q[1]);

   a_r9_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_soft_rst && !flag_q[1]) |=> !flag_q[1]);

   a_r7_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && flag_q == '0) |-> !irq);

   a_r10_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> (bus_rdata == '0));
endmodule

bind usbd_ctl_reg usbd_ctl_reg_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
   .SET_WINS(SET_WINS), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .ev_suspend(ev_suspend), .irq(irq), .ctrl_soft_rst(ctrl_soft_rst),
   .pad_hiz(pad_hiz), .resume_pulse(resume_pulse), .flag_q(flag_q)
);

// File: tb/usbd_ctl_reg_bench.sv
`timescale 1ns/1ps
module usbd_ctl_reg_bench;
   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          line_rst_active = 1'b0;
   logic          ev_host_reset = 1'b0, ev_suspend = 1'b0, ev_resume = 1'b0;
   logic          irq, ctrl_soft_rst, pad_hiz, resume_pulse;

   int total = 0;
   int bad   = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   usbd_ctl_reg u_usbd_ctl_reg (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .line_rst_active(line_rst_active), .ev_host_reset(ev_host_reset),
      .ev_suspend(ev_suspend), .ev_resume(ev_resume), .irq(irq),
      .ctrl_soft_rst(ctrl_soft_rst), .pad_hiz(pad_hiz),
      .resume_pulse(resume_pulse)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; bus_addr = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0; bus_addr = '0;
      #1;
   endtask

   task automatic pulse(input logic [2:0] f);
      @(negedge clk);
      ev_host_reset = f[2]; ev_suspend = f[1]; ev_resume = f[0];
      @(negedge clk);
      ev_host_reset = 1'b0; ev_suspend = 1'b0; ev_resume = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      logic [DW-1:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd('0, r); chk("R1 reset word", r, 32'hA2);
      chk("R1 soft reset", ctrl_soft_rst, 1);
      chk("R1 pad hiz", pad_hiz, 1);
      chk("R1 irq", irq, 0);
      // R3 live line bit
      line_rst_active = 1'b1; rd('0, r); chk("R3 line bit low", r[1], 0);
      line_rst_active = 1'b0; rd('0, r); chk("R3 line bit high", r[1], 1);
      // R10 other address, idle bus
      rd(4'h1, r); chk("R10 other addr read", r, 0);
      wr(4'h1, 32'h0000_0001);
      chk("R10 other addr write ignored", ctrl_soft_rst, 1);
      wr('0, 32'hFFFF_FF00 | 32'hA0);
      rd('0, r); chk("R10 reserved bits read 0", r, 32'hA2);
      chk("R10 idle rdata", bus_rdata, 0);
      // R9 events ignored while disabled
      pulse(3'b111);
      rd('0, r); chk("R9 flags unchanged", r & 32'h58, 0);
      // R4 wake while disabled: no pulse
      wr('0, 32'hA4); chk("R4 no pulse disabled", resume_pulse, 0);
      // R2 enable
      wr('0, 32'hA1);
      chk("R2 soft reset off", ctrl_soft_rst, 0);
      chk("R2 pad driven", pad_hiz, 0);
      rd('0, r); chk("R2 readback", r, 32'hA3);
      // R4 wake pulse
      wr('0, 32'hA5);
      chk("R4 pulse high", resume_pulse, 1);
      @(negedge clk); chk("R4 pulse one cycle", resume_pulse, 0);
      rd('0, r); chk("R4 wake reads 0", r[2], 0);
      wr('0, 32'hA1); chk("R4 write 0 no pulse", resume_pulse, 0);
      // R5 stickiness and selective clear
      pulse(3'b010);
      rd('0, r); chk("R5 suspend flag set", r[4], 1);
      wr('0, 32'hA1 | 32'h48);
      rd('0, r); chk("R5 other w1c no effect", r[4], 1);
      wr('0, 32'hA1 | 32'h10);
      rd('0, r); chk("R5 w1c clears", r[4], 0);
      // R6 R7 sweep masks x flags
      for (int m = 0; m < 4; m++) begin
         for (int f = 0; f < 8; f++) begin
            logic rem, srm, e_irq;
            logic [DW-1:0] e_word;
            rem = m[1]; srm = m[0];
            wr('0, {24'h0, rem, 1'b1, srm, 1'b1, 1'b1, 3'b001});
            if (f != 0) pulse(f[2:0]);
            e_irq = (f[2] & ~rem) | ((f[1] | f[0]) & ~srm);
            chk("R7 irq", irq, e_irq);
            rd('0, r);
            e_word = {24'h0, rem, f[2], srm, f[1], f[0], 3'b011};
            chk("R6 word", r, e_word);
         end
      end
      // R8 set wins against clear
      wr('0, 32'h59);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = '0; bus_wdata = 32'h11;
      ev_suspend = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; ev_suspend = 1'b0;
      rd('0, r); chk("R8 set beats clear", r[4], 1);
      chk("R8 irq", irq, 1);
      // R2 disable again
      wr('0, 32'hA0);
      chk("R2 soft reset back on", ctrl_soft_rst, 1);
      chk("R2 pad hiz back", pad_hiz, 1);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule